// File: doc/BRIEF.md
# Four-Bit Lookahead Add/Subtract Slice

This block is the arithmetic part of a four-cell logic block in a programmable fabric. Each of the four cells forms its result bit as the XOR of its A operand, its B operand and the carry that reaches that cell. The carry into each upper cell, and the carry leaving the group, come from flat generate/propagate lookahead terms built from all four operand pairs and the group carry-in. There is no bit-by-bit ripple inside the group.

A configuration bit lets the add/sub select input invert every B bit before it enters the carry and sum logic. With that bit set, the select high and the group carry-in held at 1, the slice computes A minus B. Wider words are built by wiring the carry-out of one slice straight into the carry-in of the next. Between groups the carry ripples, and no second-level lookahead spans them. The first carry-in of a chain is a constant 0 or 1, or an external carry flag. With B tied low and carry-in high the slice increments A, so only one operand input per bit is in use.

Top module: `lookahead_addsub_slice`

## Requirements
- R1: Every bit i of `sum_out` equals `a_in[i]` XOR B'[i] XOR the carry into bit i. B' is `b_in` inverted when both `inv_en` and `sub_sel` are 1, and is `b_in` unchanged otherwise. The carry into bit 0 is `carry_in`.
- R2: `carry_out` equals bit 4 of the 5-bit sum `a_in + B' + carry_in`.
- R3: While `inv_en` is 0, `sub_sel` has no effect. The outputs equal `a_in + b_in + carry_in`.
- R4: With `inv_en`=1, `sub_sel`=1 and `carry_in`=1, `sum_out` is `(a_in - b_in) mod 16`. `carry_out` is 1 exactly when `a_in >= b_in`, that is, when no borrow occurs.
- R5: With `inv_en`=1 and `sub_sel`=0, the slice adds `a_in + b_in + carry_in` without inversion.
- R6: With `b_in`=0 and `carry_in`=1 (increment), `sum_out` is `(a_in + 1) mod 16`. `carry_out` is 1 only when `a_in` is 15.
- R7: Four slices chained carry-out to carry-in form a 16-bit adder/subtractor. The 17-bit result matches integer arithmetic, including the final carry or no-borrow flag.
- R8: When every bit pair propagates and none generates (`a_in` equals the inverse of B'), `carry_out` equals `carry_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 4 | First operand, one bit per cell |
| b_in | input | 4 | Second operand, inverted under subtraction |
| sub_sel | input | 1 | Add (0) / subtract (1) select |
| inv_en | input | 1 | Configuration bit letting `sub_sel` invert B |
| carry_in | input | 1 | Group carry-in from the previous slice or the chain source |
| sum_out | output | 4 | Result bits |
| carry_out | output | 1 | Group carry-out from lookahead |

## Verification
A single slice is swept through every combination of both operands, carry-in, select and enable. Results are compared against integer sums and differences. This separates a wrong carry term at any bit position, a select that leaks through while the enable is off, and a subtraction that forgets the inversion.

Two dedicated pattern groups target specific carry paths. The all-propagate patterns isolate the path from `carry_in` to `carry_out`. The increment patterns isolate the single-operand carry, which reaches bit 4 only at 15.

A four-slice chain is run with walking and boundary words such as 0xFFFF+1, 0−1 and 0x8000−0x8000, plus a pseudo-random series. These show whether the carries pass correctly across the group boundaries.

// File: rtl/lookahead_addsub_slice.sv
module lookahead_addsub_slice #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         sub_sel,
  input  logic         inv_en,
  input  logic         carry_in,
  output logic [W-1:0] sum_out,
  output logic         carry_out
);

  logic [W-1:0] b_eff;
  logic [W-1:0] gen;
  logic [W-1:0] prop;
  logic [W:0]   cy;

  assign b_eff = b_in ^ {W{sub_sel & inv_en}};
  assign gen   = a_in & b_eff;
  assign prop  = a_in | b_eff;

  // each carry is a flat sum of products over all lower bit pairs
  always_comb begin
    cy    = '0;
    cy[0] = carry_in;
    for (int k = 1; k <= W; k++) begin
      logic acc;
      logic pall;
      acc  = 1'b0;
      pall = 1'b1;
      for (int j = W - 1; j >= 0; j--) begin
        if (j < k) begin
          acc  = acc | (pall & gen[j]);
          pall = pall & prop[j];
        end
      end
      cy[k] = acc | (pall & carry_in);
    end
  end

  assign sum_out   = a_in ^ b_eff ^ cy[W-1:0];
  assign carry_out = cy[W];

endmodule

// File: rtl/lookahead_addsub_slice_chk.sv
module lookahead_addsub_slice_chk #(
  parameter int W = 4
) (
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         sub_sel,
  input logic         inv_en,
  input logic         carry_in,
  input logic [W-1:0] sum_out,
  input logic         carry_out
);

  logic [W-1:0] b_chk;
  logic [W:0]   tot_eff;
  logic [W:0]   tot_raw;
  logic [W-1:0] diff;

  always_comb begin
    b_chk   = (inv_en && sub_sel) ? ~b_in : b_in;
    tot_eff = {1'b0, a_in} + {1'b0, b_chk} + {{W{1'b0}}, carry_in};
    tot_raw = {1'b0, a_in} + {1'b0, b_in} + {{W{1'b0}}, carry_in};
    diff    = a_in - b_in;

    a_r2_total: assert ({carry_out, sum_out} == tot_eff)
      else $error("R2 slice total mismatch");
    if (!inv_en) begin
      a_r3_sel_ignored: assert ({carry_out, sum_out} == tot_raw)
        else $error("R3 select leaked with enable off");
    end
    if (inv_en && sub_sel && carry_in) begin
      a_r4_sub: assert (sum_out == diff && carry_out == (a_in >= b_in))
        else $error("R4 subtraction mismatch");
    end
    if (a_in == ~b_chk) begin
      a_r8_pass: assert (carry_out == carry_in)
        else $error("R8 propagate path mismatch");
    end
  end

endmodule

bind lookahead_addsub_slice lookahead_addsub_slice_chk #(.W(W)) u_chk (.*);

// File: tb/sim_lookahead_addsub_slice.sv
module sim_lookahead_addsub_slice;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int bad    = 0;
  bit done   = 0;

  logic [3:0] a, b, s;
  logic sub, en, ci, co;

  lookahead_addsub_slice u0 (
    .a_in(a), .b_in(b), .sub_sel(sub), .inv_en(en), .carry_in(ci),
    .sum_out(s), .carry_out(co)
  );

  logic [15:0] wa, wb, ws;
  logic wsub;
  logic [4:0] wc;

  assign wc[0] = wsub;
  for (genvar g = 0; g < 4; g++) begin : g_chain
    lookahead_addsub_slice u_c (
      .a_in(wa[4*g+3:4*g]), .b_in(wb[4*g+3:4*g]), .sub_sel(wsub),
      .inv_en(1'b1), .carry_in(wc[g]),
      .sum_out(ws[4*g+3:4*g]), .carry_out(wc[g+1])
    );
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] ta, input logic [3:0] tb_,
                       input logic tsub, input logic ten, input logic tci);
    @(negedge clk);
    a = ta; b = tb_; sub = tsub; en = ten; ci = tci;
    @(posedge clk);
    #1;
  endtask

  task automatic wide(input logic [15:0] x, input logic [15:0] y, input logic op);
    int exp;
    @(negedge clk);
    wa = x; wb = y; wsub = op;
    @(posedge clk);
    #1;
    if (op) exp = int'(x) + int'(~y & 16'hFFFF) + 1;
    else    exp = int'(x) + int'(y);
    chk("R7", int'({wc[4], ws}), exp);
  endtask

  initial begin
    a = 0; b = 0; sub = 0; en = 0; ci = 0;
    wa = 0; wb = 0; wsub = 0;
    @(posedge clk); #1;
    chk("R1 idle", int'({co, s}), 0);

    for (int m = 0; m < 8; m++) begin
      for (int x = 0; x < 16; x++) begin
        for (int y = 0; y < 16; y++) begin
          logic te, tsb, tc;
          int yb, tot;
          te = m[2]; tsb = m[1]; tc = m[0];
          apply(4'(x), 4'(y), tsb, te, tc);
          yb  = (te && tsb) ? (15 - y) : y;
          tot = x + yb + int'(tc);
          chk("R1", int'(s), tot % 16);
          chk("R2", int'(co), tot / 16);
          if (!te && tsb) chk("R3", int'({co, s}), x + y + int'(tc));
          if (te && !tsb) chk("R5", int'({co, s}), x + y + int'(tc));
          if (te && tsb && tc) begin
            chk("R4 diff", int'(s), (x - y + 16) % 16);
            chk("R4 noborrow", int'(co), (x >= y) ? 1 : 0);
          end
        end
      end
    end

    for (int x = 0; x < 16; x++) begin
      apply(4'(x), 4'h0, 1'b0, 1'b1, 1'b1);
      chk("R6 inc", int'(s), (x + 1) % 16);
      chk("R6 carry", int'(co), (x == 15) ? 1 : 0);
    end

    for (int x = 0; x < 16; x++) begin
      for (int c = 0; c < 2; c++) begin
        apply(4'(x), ~4'(x), 1'b0, 1'b0, c[0]);
        chk("R8 add", int'(co), c);
        apply(4'(x), 4'(x), 1'b1, 1'b1, c[0]);
        chk("R8 sub", int'(co), c);
      end
    end

    wide(16'hFFFF, 16'h0001, 1'b0);
    wide(16'h0000, 16'h0001, 1'b1);
    wide(16'h8000, 16'h8000, 1'b1);
    wide(16'h8000, 16'h8000, 1'b0);
    wide(16'h0FFF, 16'h0001, 1'b0);
    wide(16'h1000, 16'h0001, 1'b1);
    wide(16'hFFFF, 16'hFFFF, 1'b0);
    wide(16'h1234, 16'h1234, 1'b1);
    for (int i = 0; i < 16; i++) wide(16'h1 << i, 16'hFFFF, 1'b0);
    begin
      logic [15:0] r;
      r = 16'hACE1;
      for (int i = 0; i < 200; i++) begin
        logic [15:0] q;
        r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
        q = {r[7:0], r[15:8]} ^ 16'h5A3C;
        wide(r, q, r[0]);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      bad++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule